// File: doc/BRIEF.md
# Parallel Binary Image Shrinking Array

This block takes a small black-and-white image in serially, one pixel per clock, and holds it in an array of one-bit cells, one cell per pixel. It then runs a series of shrink steps. In each step every cell computes its next value from its own bit and its left, upper and upper-left neighbours, and all cells update on the same clock edge. Each connected shape slides toward its lower-right corner and thins down until it disappears.

Before a pixel that has lost all four edge neighbours disappears, it is recorded in a marker plane. Each shape therefore leaves one marker behind. When the image is empty, or when the step limit is reached, the marker plane is shifted out serially in raster order. The number of markers set is reported as the object count.

Typical use: pulse `start`, stream `ROWS*COLS` pixels on `ser_in` (top row first, left to right), wait for `done`, then collect `ROWS*COLS` marker bits while `ser_out_valid` is high.

Top module: `bin_shrink_array`

## Requirements
- R1: A synchronous active-high `rst` clears the pixel cells, the marker plane and the counter. While reset is applied and after it, `done`, `ser_out_valid` and `object_count` are 0.
- R2: After a `start` pulse, the block takes exactly ROWS*COLS pixel bits, one on each clock with `ser_in_valid` high, in raster order: the first bit is row 0 column 0 and row r column c is bit number r*COLS+c. Clocks with `ser_in_valid` low take nothing.
- R3: In one shrink step every cell updates on the same edge. The new value is 1 only when the pixel is 1 and at least one of its left, upper or upper-left neighbours is 1. Positions outside the image count as 0.
- R4: In a shrink step, any pixel that is 1 while its upper, lower, left and right neighbours are all 0 sets its marker bit. A marker bit that is set stays set until it is shifted out or a new `start` arrives.
- R5: Steps run one per clock. The control stops at the first clock on which the image is all zero or MAX_STEPS steps have already run (default ROWS+COLS). With S steps run, `done` and `ser_out_valid` first read high after the (S+2)-th rising edge, counting the edge that takes the last pixel as the first.
- R6: Unloading keeps `ser_out_valid` high for exactly ROWS*COLS consecutive clocks. `ser_out` carries the marker bits in the same raster order as the load.
- R7: `object_count` equals the number of distinct marker bits set, and it holds steady while `done` is high.
- R8: `done` stays high after unloading until the next `start`. That `start` lowers `done` and clears the count and markers on the same edge.
- R9: `start` and `ser_in_valid` have no effect while steps are running or while markers are being shifted out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new frame (honoured when idle or finished) |
| ser_in | input | 1 | Serial pixel bit, 1 = object |
| ser_in_valid | input | 1 | `ser_in` carries a pixel this clock |
| ser_out | output | 1 | Serial marker bit |
| ser_out_valid | output | 1 | `ser_out` carries a marker bit this clock |
| done | output | 1 | Shrinking finished; count is valid |
| object_count | output | $clog2(ROWS*COLS+1) | Number of markers set |

## Verification
The bench computes S, the number of steps, from its own model of the shrink rule. It expects `done` and `ser_out_valid` to stay low for the S+1 clocks after the final pixel is taken, and to rise after the (S+2)-th edge. The N marker bits then follow, one per clock. Inputs are driven on the falling edge and outputs are sampled on the following falling edge, so each check reads the value that exactly one rising edge has produced. Stray `start` and `ser_in_valid` pulses are placed so that they reach a step edge or an unload edge, and the unchanged timeline and markers show that they were ignored.

// File: rtl/bin_shrink_pkg.sv
package bin_shrink_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOAD,
      ST_SHRINK,
      ST_UNLOAD,
      ST_FIN
   } shrink_state_t;

endpackage

// File: rtl/shrink_cell.sv
module shrink_cell (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic load_en,
   input  logic load_in,
   input  logic step_en,
   input  logic nb_left,
   input  logic nb_up,
   input  logic nb_upleft,
   input  logic nb_right,
   input  logic nb_down,
   input  logic mark_shift,
   input  logic mark_in,
   output logic pix,
   output logic mark,
   output logic iso_fresh
);

   logic keep;
   logic alone;

   // survives only with support from the upper-left quadrant
   assign keep  = pix & (nb_left | nb_up | nb_upleft);
   assign alone = pix & ~(nb_left | nb_up | nb_right | nb_down);
   assign iso_fresh = alone & ~mark;

   always_ff @(posedge clk) begin
      if (rst || clr)
         pix <= 1'b0;
      else if (load_en)
         pix <= load_in;
      else if (step_en)
         pix <= keep;
   end

   always_ff @(posedge clk) begin
      if (rst || clr)
         mark <= 1'b0;
      else if (mark_shift)
         mark <= mark_in;
      else if (step_en && alone)
         mark <= 1'b1;
   end

   // R3: a step never turns an empty cell on
   p_no_grow_r3: assert property (@(posedge clk) disable iff (rst)
      (step_en && !pix) |=> !pix);

   // R4: a set marker survives until shifted or cleared
   p_mark_sticky_r4: assert property (@(posedge clk) disable iff (rst)
      (mark && !mark_shift && !clr) |=> mark);

endmodule

// File: rtl/shrink_ctrl.sv
module shrink_ctrl
   import bin_shrink_pkg::*;
#(
   parameter int NPIX      = 64,
   parameter int MAX_STEPS = 16
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic in_valid,
   input  logic img_empty,
   output logic clr,
   output logic load_en,
   output logic step_en,
   output logic mark_shift,
   output logic done,
   output logic out_valid
);

   localparam int PW = $clog2(NPIX + 1);
   localparam int SW = $clog2(MAX_STEPS + 1);

   shrink_state_t state_q, state_d;
   logic [PW-1:0] pos_q, pos_d;
   logic [SW-1:0] steps_q, steps_d;

   always_comb begin
      state_d    = state_q;
      pos_d      = pos_q;
      steps_d    = steps_q;
      clr        = 1'b0;
      load_en    = 1'b0;
      step_en    = 1'b0;
      mark_shift = 1'b0;
      case (state_q)
         ST_IDLE, ST_FIN: begin
            if (start) begin
               clr     = 1'b1;
               pos_d   = '0;
               steps_d = '0;
               state_d = ST_LOAD;
            end
         end
         ST_LOAD: begin
            if (in_valid) begin
               load_en = 1'b1;
               pos_d   = pos_q + 1'b1;
               if (pos_q == PW'(NPIX - 1)) begin
                  pos_d   = '0;
                  state_d = ST_SHRINK;
               end
            end
         end
         ST_SHRINK: begin
            if (img_empty || steps_q == SW'(MAX_STEPS)) begin
               pos_d   = '0;
               state_d = ST_UNLOAD;
            end else begin
               step_en = 1'b1;
               steps_d = steps_q + 1'b1;
            end
         end
         ST_UNLOAD: begin
            mark_shift = 1'b1;
            pos_d      = pos_q + 1'b1;
            if (pos_q == PW'(NPIX - 1))
               state_d = ST_FIN;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= ST_IDLE;
         pos_q   <= '0;
         steps_q <= '0;
      end else begin
         state_q <= state_d;
         pos_q   <= pos_d;
         steps_q <= steps_d;
      end
   end

   assign done      = (state_q == ST_UNLOAD) || (state_q == ST_FIN);
   assign out_valid = (state_q == ST_UNLOAD);

   // R6: markers only leave after shrinking has ended
   p_valid_needs_done_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> done);

   // R5: no step is spent on an empty image
   p_no_step_empty_r5: assert property (@(posedge clk) disable iff (rst)
      step_en |-> !img_empty);

   // R5: the step counter never passes its limit
   p_step_limit_r5: assert property (@(posedge clk) disable iff (rst)
      steps_q <= SW'(MAX_STEPS));

   // R9: load, step and unload never overlap
   p_one_action_r9: assert property (@(posedge clk) disable iff (rst)
      $onehot0({load_en, step_en, mark_shift}));

   // R8: done holds until a new start
   p_done_holds_r8: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> done);

endmodule

// File: rtl/bin_shrink_array.sv
module bin_shrink_array #(
   parameter int ROWS      = 8,
   parameter int COLS      = 8,
   parameter int MAX_STEPS = ROWS + COLS
) (
   input  logic                               clk,
   input  logic                               rst,
   input  logic                               start,
   input  logic                               ser_in,
   input  logic                               ser_in_valid,
   output logic                               ser_out,
   output logic                               ser_out_valid,
   output logic                               done,
   output logic [$clog2(ROWS*COLS+1)-1:0]     object_count
);

   localparam int NPIX = ROWS * COLS;
   localparam int CW   = $clog2(NPIX + 1);

   if (ROWS < 2 || COLS < 2) begin : g_bad_dims
      $error("bin_shrink_array: ROWS and COLS must each be at least 2");
   end
   if (MAX_STEPS < 1) begin : g_bad_steps
      $error("bin_shrink_array: MAX_STEPS must be at least 1");
   end

   logic            clr, load_en, step_en, mark_shift;
   logic [NPIX-1:0] img, mark, iso_fresh;
   logic [NPIX-1:0] nb_l, nb_u, nb_ul, nb_r, nb_d;
   logic [NPIX-1:0] load_src, mark_src;
   logic [CW-1:0]   fresh_sum, count_q;

   shrink_ctrl #(
      .NPIX      (NPIX),
      .MAX_STEPS (MAX_STEPS)
   ) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .in_valid   (ser_in_valid),
      .img_empty  (~|img),
      .clr        (clr),
      .load_en    (load_en),
      .step_en    (step_en),
      .mark_shift (mark_shift),
      .done       (done),
      .out_valid  (ser_out_valid)
   );

   // raster shift: new bit enters at the far end, first bit lands in cell 0
   assign load_src = {ser_in, img[NPIX-1:1]};
   assign mark_src = {1'b0, mark[NPIX-1:1]};

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int IDX = r * COLS + c;

         if (c > 0) begin : g_l
            assign nb_l[IDX] = img[IDX-1];
         end else begin : g_nl
            assign nb_l[IDX] = 1'b0;
         end
         if (r > 0) begin : g_u
            assign nb_u[IDX] = img[IDX-COLS];
         end else begin : g_nu
            assign nb_u[IDX] = 1'b0;
         end
         if (r > 0 && c > 0) begin : g_ul
            assign nb_ul[IDX] = img[IDX-COLS-1];
         end else begin : g_nul
            assign nb_ul[IDX] = 1'b0;
         end
         if (c < COLS - 1) begin : g_r
            assign nb_r[IDX] = img[IDX+1];
         end else begin : g_nr
            assign nb_r[IDX] = 1'b0;
         end
         if (r < ROWS - 1) begin : g_d
            assign nb_d[IDX] = img[IDX+COLS];
         end else begin : g_nd
            assign nb_d[IDX] = 1'b0;
         end

         shrink_cell u_cell (
            .clk        (clk),
            .rst        (rst),
            .clr        (clr),
            .load_en    (load_en),
            .load_in    (load_src[IDX]),
            .step_en    (step_en),
            .nb_left    (nb_l[IDX]),
            .nb_up      (nb_u[IDX]),
            .nb_upleft  (nb_ul[IDX]),
            .nb_right   (nb_r[IDX]),
            .nb_down    (nb_d[IDX]),
            .mark_shift (mark_shift),
            .mark_in    (mark_src[IDX]),
            .pix        (img[IDX]),
            .mark       (mark[IDX]),
            .iso_fresh  (iso_fresh[IDX])
         );
      end
   end

   always_comb begin
      fresh_sum = '0;
      for (int i = 0; i < NPIX; i++)
         fresh_sum = fresh_sum + CW'(iso_fresh[i]);
   end

   always_ff @(posedge clk) begin
      if (rst || clr)
         count_q <= '0;
      else if (step_en)
         count_q <= count_q + fresh_sum;
   end

   assign object_count = count_q;
   assign ser_out      = ser_out_valid & mark[0];

   // R7: never more markers than pixels
   p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
      count_q <= CW'(NPIX));

   // R7: the reported count is frozen while done
   p_count_frozen_r7: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> $stable(object_count));

endmodule

// File: tb/bin_shrink_array_test.sv
module bin_shrink_array_test;

   localparam int R   = 8;
   localparam int C   = 8;
   localparam int N   = R * C;
   localparam int CAP = 12;

   logic       clk = 1'b0;
   logic       rst, start, ser_in, ser_in_valid;
   logic       ser_out, ser_out_valid, done;
   logic [6:0] object_count;

   int errors = 0;
   int checks = 0;
   int pic[N];
   int exp_mark[N];
   int got[N];
   int exp_steps, exp_count;
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   bin_shrink_array #(.ROWS(R), .COLS(C), .MAX_STEPS(CAP)) uut (
      .clk           (clk),
      .rst           (rst),
      .start         (start),
      .ser_in        (ser_in),
      .ser_in_valid  (ser_in_valid),
      .ser_out       (ser_out),
      .ser_out_valid (ser_out_valid),
      .done          (done),
      .object_count  (object_count)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int px(input int a[N], input int r, input int c);
      if (r < 0 || c < 0 || r >= R || c >= C) return 0;
      return a[r*C+c];
   endfunction

   // behavioural model of the whole shrink run
   task automatic predict();
      int cur[N];
      int nxt[N];
      int any;
      cur = pic;
      exp_steps = 0;
      exp_count = 0;
      for (int i = 0; i < N; i++) exp_mark[i] = 0;
      forever begin
         any = 0;
         for (int i = 0; i < N; i++) any += cur[i];
         if (any == 0 || exp_steps == CAP) break;
         for (int r = 0; r < R; r++) begin
            for (int c = 0; c < C; c++) begin
               int s;
               s = cur[r*C+c];
               if (s == 1 && px(cur, r-1, c) == 0 && px(cur, r+1, c) == 0 &&
                   px(cur, r, c-1) == 0 && px(cur, r, c+1) == 0 &&
                   exp_mark[r*C+c] == 0) begin
                  exp_mark[r*C+c] = 1;
                  exp_count++;
               end
               nxt[r*C+c] = (s == 1 && (px(cur, r, c-1) + px(cur, r-1, c) +
                             px(cur, r-1, c-1)) > 0) ? 1 : 0;
            end
         end
         cur = nxt;
         exp_steps++;
      end
   endtask

   task automatic clear_pic();
      for (int i = 0; i < N; i++) pic[i] = 0;
   endtask

   task automatic do_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      chk(done == 1'b0, "R8 done after start", int'(done), 0);
      chk(object_count == 7'd0, "R8 count cleared", int'(object_count), 0);
   endtask

   task automatic load(input bit gaps);
      for (int i = 0; i < N; i++) begin
         if (gaps && (i % 5 == 2)) begin
            ser_in = ~pic[i][0];
            ser_in_valid = 1'b0;
            @(negedge clk);
         end
         ser_in = pic[i][0];
         ser_in_valid = 1'b1;
         @(negedge clk);
      end
      ser_in_valid = 1'b0;
      ser_in = 1'b0;
   endtask

   // current time: falling edge just after the edge that took the last pixel
   task automatic run(input bit glitch);
      predict();
      for (int j = 0; j <= exp_steps; j++) begin
         chk(done == 1'b0, "R5 done low while shrinking", int'(done), 0);
         chk(ser_out_valid == 1'b0, "R5 valid low while shrinking", int'(ser_out_valid), 0);
         if (glitch && j == 0 && exp_steps >= 1) begin
            start = 1'b1; ser_in_valid = 1'b1; ser_in = 1'b1;   // R9 stray inputs
         end else begin
            start = 1'b0; ser_in_valid = 1'b0; ser_in = 1'b0;
         end
         @(negedge clk);
      end
      for (int i = 0; i < N; i++) begin
         chk(ser_out_valid == 1'b1, "R6 valid during unload", int'(ser_out_valid), 1);
         chk(done == 1'b1, "R5 done at unload", int'(done), 1);
         chk(int'(ser_out) == exp_mark[i], "R6 marker bit", int'(ser_out), exp_mark[i]);
         chk(int'(object_count) == exp_count, "R7 count", int'(object_count), exp_count);
         got[i] = int'(ser_out);
         start = (glitch && i == 3);   // R9 start during unload
         ser_in_valid = (glitch && i == 3);
         @(negedge clk);
      end
      start = 1'b0;
      ser_in_valid = 1'b0;
      for (int k = 0; k < 3; k++) begin
         chk(done == 1'b1, "R8 done held", int'(done), 1);
         chk(ser_out_valid == 1'b0, "R6 valid ends", int'(ser_out_valid), 0);
         chk(int'(object_count) == exp_count, "R7 count held", int'(object_count), exp_count);
         @(negedge clk);
      end
   endtask

   function automatic int rnd();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return int'(lfsr[3:0]);
   endfunction

   initial begin
      #(5.0 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst = 1'b1; start = 1'b0; ser_in = 1'b0; ser_in_valid = 1'b0;
      repeat (3) @(negedge clk);
      chk(done == 1'b0, "R1 done in reset", int'(done), 0);
      chk(ser_out_valid == 1'b0, "R1 valid in reset", int'(ser_out_valid), 0);
      chk(object_count == 7'd0, "R1 count in reset", int'(object_count), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(done == 1'b0, "R1 done after reset", int'(done), 0);

      // two 2x2 blocks on a diagonal: markers at (1,1) and (3,3)
      clear_pic();
      pic[0] = 1; pic[1] = 1; pic[8] = 1; pic[9] = 1;
      pic[18] = 1; pic[19] = 1; pic[26] = 1; pic[27] = 1;
      do_start();
      load(1'b0);
      run(1'b0);
      chk(got[9] == 1, "R4 marker (1,1)", got[9], 1);
      chk(got[27] == 1, "R4 marker (3,3)", got[27], 1);
      chk(object_count == 7'd2, "R3 two objects", int'(object_count), 2);

      // empty frame: no steps at all
      clear_pic();
      do_start();
      load(1'b0);
      run(1'b0);
      chk(object_count == 7'd0, "R5 empty frame count", int'(object_count), 0);

      // single pixel at (4,4), loaded with gaps
      clear_pic();
      pic[36] = 1;
      do_start();
      load(1'b1);
      run(1'b0);
      chk(got[36] == 1, "R2 position after gapped load", got[36], 1);
      chk(object_count == 7'd1, "R4 lone pixel kept", int'(object_count), 1);

      // full frame: stops on the step limit with pixels left
      for (int i = 0; i < N; i++) pic[i] = 1;
      do_start();
      load(1'b0);
      run(1'b0);
      chk(object_count == 7'd0, "R5 cap reached count", int'(object_count), 0);

      // sparse pseudo-random frames with stray inputs
      for (int t = 0; t < 4; t++) begin
         for (int i = 0; i < N; i++) pic[i] = (rnd() < 4) ? 1 : 0;
         do_start();
         load(t[0]);
         run(1'b1);
      end

      // bars and a block
      clear_pic();
      for (int r = 0; r < R; r++) pic[r*C+1] = 1;
      for (int c = 3; c < C; c++) pic[2*C+c] = 1;
      pic[5*C+5] = 1; pic[5*C+6] = 1; pic[6*C+5] = 1; pic[6*C+6] = 1;
      do_start();
      load(1'b1);
      run(1'b1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule